// File: doc/BRIEF.md
# Synchronized NCO Frequency Load

This block moves a frequency control word into the phase-increment register of a numerically controlled oscillator when a load is requested, and it contains the phase accumulator that the increment drives. A load can be requested in three ways: by an asynchronous external load pin, by a control-register bit, or by a single-cycle timing strobe from a loop filter. The pin and the register bit are combined into one level. A load starts when that level rises, so a rise on either source counts only while the other source is low.

The combined level goes through a two-flop synchronizer to the receive master clock, followed by a rising-edge detector. The strobe goes through a delay line of matching length, so every source has the same timing. Call edge k the first clock edge that samples a request. The word on `freq_word` is captured at edge k+2, and it becomes the active increment at edge k+5, the sixth edge counting edge k.

Between capture and commit the block reports itself busy. Any request that reaches the capture stage in that window is dropped and sets a sticky error flag. The accumulator adds the active increment on every clock edge and exposes its upper bits as the phase.

Top module: `nco_load_ctl`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `step_out` and `phase_out` are zero and `busy` and `load_err` are low.
- R2: A rise of `ld_pin` while `ld_reg_bit` is low, first sampled at edge k, makes `step_out` equal to the `freq_word` value present at edge k+2, starting right after edge k+5. Before edge k+5, `step_out` keeps its previous value.
- R3: A rise of `ld_reg_bit` while `ld_pin` is low has the same timing as R2.
- R4: A `ld_strobe` pulse sampled high at edge k has the same timing as R2.
- R5: No load starts when the combined level does not rise. This covers a rise of one source while the other is high, a fall of either source, and a level held high.
- R6: Changes to `freq_word` after the capture edge k+2 do not affect the committed increment.
- R7: `busy` is 1 after edges k+2, k+3 and k+4 of an accepted load. It is 0 after edge k+1, 0 after edge k+5, and 0 when no load is in progress.
- R8: A second request first sampled 1, 2 or 3 edges after an accepted request's edge k is dropped. `step_out` keeps the first word, and no second busy period follows.
- R9: A dropped request sets `load_err`, which stays 1 until reset. Accepted requests leave it at 0.
- R10: A second request first sampled 4 or more edges after edge k is accepted and commits its own word with the R2 timing.
- R11: On every edge the 32-bit accumulator adds the `step_out` value held before that edge, wrapping modulo 2^32. `phase_out` equals the accumulator's upper 12 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive master clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole data path |
| ld_pin | input | 1 | Asynchronous external load request level |
| ld_reg_bit | input | 1 | Load request level from a control register, ORed with `ld_pin` |
| ld_strobe | input | 1 | Single-cycle load strobe from loop-filter timing |
| freq_word | input | ACC_W | Frequency control word captured by a load |
| step_out | output | ACC_W | Active phase increment |
| phase_out | output | PH_W | Upper bits of the phase accumulator |
| busy | output | 1 | A load sequence is between capture and commit |
| load_err | output | 1 | Sticky flag: a request arrived while busy |

## Verification
The hardest case is a second request that arrives while a load sequence is still running. It has to land at each distinct offset from the first, and it has to come from a different source than the first, so that the edge detector and the delay line are both exercised together. The bench starts each run from reset with a strobe-driven load. It then pulses the pin at offsets of one to six edges later, with a different word already on the bus, and computes from the offset alone whether the second word must win and whether the error flag must be set. Accumulator sweeps with wrapping increments check the phase edge by edge against products computed in the bench.

// File: rtl/nco_load_pkg.sv
`timescale 1ns/1ps
package nco_load_pkg;

    localparam int unsigned DEF_ACC_W  = 32;
    localparam int unsigned DEF_PH_W   = 12;
    localparam int unsigned DEF_SYNC   = 2;
    localparam int unsigned DEF_LAT    = 6;

    // Edges between capture and commit: total latency minus the alignment stages
    // minus the capture edge itself.
    function automatic int unsigned hold_edges(input int unsigned lat, input int unsigned sync);
        return lat - sync - 1;
    endfunction

    typedef struct packed {
        logic busy;
        logic err;
    } seq_flags_t;

endpackage

// File: rtl/nco_ld_trigger.sv
`timescale 1ns/1ps
module nco_ld_trigger #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_a,
    input  logic lvl_b,
    input  logic strobe,
    output logic req
);

    typedef struct packed {
        logic [DEPTH-1:0] sync;
        logic             prev;
        logic [DEPTH-1:0] dly;
    } trig_t;

    trig_t st_d, st_q;
    logic  merged;

    always_comb begin
        merged       = lvl_a | lvl_b;
        st_d         = st_q;
        st_d.sync    = {st_q.sync[DEPTH-1:0], merged}[DEPTH-1:0];
        st_d.prev    = st_q.sync[DEPTH-1];
        st_d.dly     = {st_q.dly[DEPTH-1:0], strobe}[DEPTH-1:0];
        req          = (st_q.sync[DEPTH-1] & ~st_q.prev) | st_q.dly[DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/nco_ld_seq.sv
`timescale 1ns/1ps
module nco_ld_seq
    import nco_load_pkg::*;
#(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned HOLD  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [ACC_W-1:0] word,
    output logic [ACC_W-1:0] step,
    output logic             busy,
    output logic             err
);

    localparam int unsigned CNT_W = $clog2(HOLD + 1);

    typedef struct packed {
        seq_flags_t       flg;
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] hold;
        logic [ACC_W-1:0] step;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.flg.busy) begin
            if (req) st_d.flg.err = 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.flg.busy = 1'b0;
                st_d.step     = st_q.hold;
                st_d.cnt      = '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end else if (req) begin
            st_d.flg.busy = 1'b1;
            st_d.cnt      = CNT_W'(HOLD);
            st_d.hold     = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step = st_q.step;
    assign busy = st_q.flg.busy;
    assign err  = st_q.flg.err;

endmodule

// File: rtl/nco_ld_accum.sv
`timescale 1ns/1ps
module nco_ld_accum #(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] acc,
    output logic [PH_W-1:0]  phase
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.acc = st_q.acc + step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc   = st_q.acc;
    assign phase = st_q.acc[ACC_W-1 -: PH_W];

endmodule

// File: rtl/nco_load_ctl.sv
`timescale 1ns/1ps
module nco_load_ctl
    import nco_load_pkg::*;
#(
    parameter int unsigned ACC_W      = DEF_ACC_W,
    parameter int unsigned PH_W       = DEF_PH_W,
    parameter int unsigned SYNC_DEPTH = DEF_SYNC,
    parameter int unsigned LOAD_LAT   = DEF_LAT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_pin,
    input  logic             ld_reg_bit,
    input  logic             ld_strobe,
    input  logic [ACC_W-1:0] freq_word,
    output logic [ACC_W-1:0] step_out,
    output logic [PH_W-1:0]  phase_out,
    output logic             busy,
    output logic             load_err
);

    localparam int unsigned HOLD_EDGES = hold_edges(LOAD_LAT, SYNC_DEPTH);

    logic             req_w;
    logic [ACC_W-1:0] acc_w;

    nco_ld_trigger #(.DEPTH(SYNC_DEPTH)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_a  (ld_pin),
        .lvl_b  (ld_reg_bit),
        .strobe (ld_strobe),
        .req    (req_w)
    );

    nco_ld_seq #(.ACC_W(ACC_W), .HOLD(HOLD_EDGES)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_w),
        .word  (freq_word),
        .step  (step_out),
        .busy  (busy),
        .err   (load_err)
    );

    nco_ld_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step_out),
        .acc   (acc_w),
        .phase (phase_out)
    );

endmodule

// File: rtl/nco_ld_chk.sv
`timescale 1ns/1ps
module nco_ld_chk #(
    parameter int unsigned ACC_W      = 32,
    parameter int unsigned SYNC_DEPTH = 2,
    parameter int unsigned LOAD_LAT   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             load_err,
    input logic [ACC_W-1:0] step_out,
    input logic [ACC_W-1:0] acc
);

    localparam int unsigned HOLD  = LOAD_LAT - SYNC_DEPTH - 1;
    localparam int unsigned RUN_W = $clog2(HOLD + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      run_q <= '0;
        else if (!busy)                  run_q <= '0;
        else if (run_q != {RUN_W{1'b1}}) run_q <= run_q + RUN_W'(1);
    end

    // R7: every busy period lasts exactly the hold window
    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(HOLD)));

    // R2: the increment only changes as a busy period closes
    p_step_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(step_out) |-> $fell(busy));

    // R9: error flag is sticky
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |=> load_err);

    // R8: error can only appear while a sequence was running
    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_err) |-> $past(busy));

    // R11: accumulator advances by the previous increment
    p_acc_adv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc == $past(acc) + $past(step_out));

endmodule

bind nco_load_ctl nco_ld_chk #(
    .ACC_W      (ACC_W),
    .SYNC_DEPTH (SYNC_DEPTH),
    .LOAD_LAT   (LOAD_LAT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .load_err (load_err),
    .step_out (step_out),
    .acc      (acc_w)
);

// File: tb/nco_load_ctl_tb.sv
`timescale 1ns/1ps
module nco_load_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_pin = 1'b0;
    logic        ld_bit = 1'b0;
    logic        ld_stb = 1'b0;
    logic [31:0] fword = '0;
    logic [31:0] step;
    logic [11:0] phase;
    logic        busy;
    logic        err;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    nco_load_ctl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_pin     (ld_pin),
        .ld_reg_bit (ld_bit),
        .ld_strobe  (ld_stb),
        .freq_word  (fword),
        .step_out   (step),
        .phase_out  (phase),
        .busy       (busy),
        .load_err   (err)
    );

    task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", msg, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    task automatic do_reset();
        ld_pin = 1'b0; ld_bit = 1'b0; ld_stb = 1'b0; fword = '0;
        rst_n = 1'b0;
        idle(2);
        chk("R1 step in reset", step, 32'h0);
        chk("R1 busy in reset", {31'h0, busy}, 32'h0);
        rst_n = 1'b1;
        tick();
    endtask

    // src: 0 pin, 1 register bit, 2 strobe
    task automatic do_load(input int src, input logic [31:0] w, input logic [31:0] prev, input string tag);
        fword = w;
        case (src)
            0:       ld_pin = 1'b1;
            1:       ld_bit = 1'b1;
            default: ld_stb = 1'b1;
        endcase
        tick();                                   // edge k
        ld_stb = 1'b0;
        tick();                                   // edge k+1
        chk({tag, "/R7 busy low after k+1"}, {31'h0, busy}, 32'h0);
        tick();                                   // edge k+2: capture
        chk({tag, "/R7 busy high after k+2"}, {31'h0, busy}, 32'h1);
        fword = ~w;                               // R6: late change must not matter
        tick();                                   // k+3
        chk({tag, " step held after k+3"}, step, prev);
        tick();                                   // k+4
        chk({tag, " step held after k+4"}, step, prev);
        chk({tag, "/R7 busy high after k+4"}, {31'h0, busy}, 32'h1);
        tick();                                   // k+5: commit
        chk({tag, "/R6 step committed after k+5"}, step, w);
        chk({tag, "/R7 busy low after k+5"}, {31'h0, busy}, 32'h0);
        chk({tag, "/R9 no error on accepted load"}, {31'h0, err}, 32'h0);
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        total++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 step after reset", step, 32'h0);
        chk("R1 phase after reset", {20'h0, phase}, 32'h0);
        chk("R1 busy after reset", {31'h0, busy}, 32'h0);
        chk("R1 err after reset", {31'h0, err}, 32'h0);

        // R3 register-bit load, then R5 gating cases
        do_load(1, 32'h1111_2222, 32'h0, "R3");
        idle(4);
        fword = 32'hAAAA_5555;
        ld_pin = 1'b1;                            // rise while bit high
        idle(10);
        chk("R5 pin rise with bit high", step, 32'h1111_2222);
        ld_bit = 1'b0;                            // bit falls, level stays high
        idle(10);
        chk("R5 bit fall under pin high", step, 32'h1111_2222);
        ld_pin = 1'b0;                            // level falls
        idle(10);
        chk("R5 level fall", step, 32'h1111_2222);
        chk("R5 no error from gated edges", {31'h0, err}, 32'h0);

        // R2 pin load, then held-high level
        do_load(0, 32'h3C3C_0F0F, 32'h1111_2222, "R2");
        fword = 32'h7777_7777;
        idle(12);
        chk("R5 pin held high", step, 32'h3C3C_0F0F);
        ld_pin = 1'b0;
        idle(4);

        // R4 strobe load
        do_load(2, 32'h0BAD_F00D, 32'h3C3C_0F0F, "R4");
        idle(4);

        // R8/R9/R10: second request (pin pulse) at offset d after a strobe
        for (int d = 1; d <= 6; d++) begin
            do_reset();
            fword = 32'h1234_5678;
            ld_stb = 1'b1;
            if (d == 0) ld_pin = 1'b1;
            for (int t = 0; t < 16; t++) begin
                tick();                           // after edge k+t
                ld_stb = 1'b0;
                if (t == 2) fword = 32'hCAFE_0001;
                if (t == d - 1) ld_pin = 1'b1;
                if (t == d) ld_pin = 1'b0;
                if (t == d + 4)
                    chk($sformatf("R8/R10 busy at k+%0d for d=%0d", t, d), {31'h0, busy},
                        (d >= 4) ? 32'h1 : 32'h0);
            end
            chk($sformatf("R8/R10 final step d=%0d", d), step,
                (d >= 4) ? 32'hCAFE_0001 : 32'h1234_5678);
            chk($sformatf("R9 err d=%0d", d), {31'h0, err}, (d >= 4) ? 32'h0 : 32'h1);
            idle(5);
            chk($sformatf("R9 err sticky d=%0d", d), {31'h0, err}, (d >= 4) ? 32'h0 : 32'h1);
        end

        // R11: phase sweep with several increments, including wrapping ones
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w;
            case (i)
                0:       w = 32'h0123_4567;
                1:       w = 32'hFFFF_FFFF;
                2:       w = 32'h8000_0001;
                default: w = 32'h0000_1000;
            endcase
            do_reset();
            do_load(2, w, 32'h0, "R11");
            chk("R11 phase zero at commit", {20'h0, phase}, 32'h0);
            for (int m = 1; m <= 40; m++) begin
                logic [31:0] e;
                tick();
                e = w * 32'(m);
                chk($sformatf("R11 phase w=%h m=%0d", w, m), {20'h0, phase}, {20'h0, e[31:20]});
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule